// File: doc/BRIEF.md
# Chroma Interleave Sample Sequencer

A single shared converter samples luminance most of the time and gives up two positions in every thirteen to the colour-difference signals. This block decides, for each enabled sample, which signal the converter is taking. It produces a slot code, a write enable for the video memory, and an enable for subcarrier-phase samples. Inside one line, eleven video slots are followed by one U slot and then one V slot, and this repeats.

Fixed chroma positions would show up as a visible pattern on the display. To avoid that, each new line starts the cycle one slot later than the line before it. After thirteen lines every horizontal position has been sampled in every slot type, and the rotation then begins again. The vertical trigger brings the rotation back to its starting point. A U sample is never written into the video memory.

Top module: `chroma_interleave_seq`

## Requirements
- R1: After reset, the slot index and the line offset are both 0. The first enabled sample is therefore a video sample, and eleven enabled samples pass before the first U slot.
- R2: The slot index advances by one on each cycle that has `samp_en` high and no trigger, wrapping from 12 to 0. Without `samp_en` and without a trigger, the slot index holds its value.
- R3: `slot_code` decodes the current slot index as follows: indices 0 to 10 give 2'b00 (video), index 11 gives 2'b01 (U) and index 12 gives 2'b10 (V). The value 2'b11 never appears.
- R4: `vid_wr_en` is high exactly when `samp_en` is high and the current slot is not U. Video and V slots are written.
- R5: On `h_trig` (without `v_trig`), the slot index loads the line offset it had before the trigger, and the line offset advances by one modulo 13. This takes priority over `samp_en`.
- R6: On `v_trig`, the slot index and the line offset both clear to 0. This takes priority over a simultaneous `h_trig`.
- R7: `scph_en` is high only on an enabled V slot that comes before the first wrap from 12 to 0 after the most recent trigger. A line that starts at index 12 therefore gets it on its first sample only.
- R8: The k-th horizontal trigger after a vertical trigger (k counted from 0) starts its line at slot index k mod 13, so the start pattern repeats every 13 lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_en | input | 1 | Sample-clock enable; one converter sample per high cycle |
| h_trig | input | 1 | Single-cycle horizontal trigger (line start) |
| v_trig | input | 1 | Single-cycle vertical trigger (field start) |
| slot_code | output | 2 | Current slot type: 00 video, 01 U, 10 V |
| vid_wr_en | output | 1 | Video-memory write enable for the current sample |
| scph_en | output | 1 | Subcarrier-phase sample enable |

## Verification
The assertions assume that triggers are one-cycle pulses and that every input is stable around the rising edge. They also assume that a trigger arriving together with `samp_en` is meant to start a new line rather than to advance the old one. The bench changes its inputs only on the falling edge and raises each trigger for exactly one cycle. It also drives the two corner overlaps the priorities cover: a horizontal trigger together with an enable, and a vertical trigger together with a horizontal trigger.

// File: rtl/cis_pkg.sv
package cis_pkg;
   typedef enum logic [1:0] {
      SLOT_VID = 2'b00,
      SLOT_U   = 2'b01,
      SLOT_V   = 2'b10
   } slot_kind_e;
endpackage

// File: rtl/cis_line_ofs.sv
// Per-line start offset: advances modulo SLOTS on each line start, cleared at field start.
module cis_line_ofs #(
   parameter int  SLOTS  = 13,
   parameter bit  ROTATE = 1'b1,
   localparam int CW     = $clog2(SLOTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          h_trig,
   input  logic          v_trig,
   output logic [CW-1:0] ofs
);
   localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

   generate
      if (ROTATE) begin : g_rotate
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ofs <= '0;
            else if (v_trig)
               ofs <= '0;
            else if (h_trig)
               ofs <= (ofs == LAST) ? '0 : ofs + CW'(1);
         end
      end else begin : g_fixed
         assign ofs = '0;
      end
   endgenerate
endmodule

// File: rtl/cis_slot_ctr.sv
// Slot index within the interleave cycle plus the first-pass flag of the current line.
module cis_slot_ctr #(
   parameter int  SLOTS = 13,
   localparam int CW    = $clog2(SLOTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          samp_en,
   input  logic          h_trig,
   input  logic          v_trig,
   input  logic [CW-1:0] ofs_in,
   output logic [CW-1:0] slot_ix,
   output logic          first_pass
);
   localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_ix    <= '0;
         first_pass <= 1'b1;
      end else if (v_trig) begin
         slot_ix    <= '0;
         first_pass <= 1'b1;
      end else if (h_trig) begin
         slot_ix    <= ofs_in;
         first_pass <= 1'b1;
      end else if (samp_en) begin
         if (slot_ix == LAST) begin
            slot_ix    <= '0;
            first_pass <= 1'b0;
         end else begin
            slot_ix <= slot_ix + CW'(1);
         end
      end
   end
endmodule

// File: rtl/cis_decode.sv
// Slot index to slot type, write enable and subcarrier-phase enable.
module cis_decode #(
   parameter int  SLOTS     = 13,
   parameter int  VID_SLOTS = 11,
   localparam int CW        = $clog2(SLOTS)
) (
   input  logic          samp_en,
   input  logic [CW-1:0] slot_ix,
   input  logic          first_pass,
   output logic [1:0]    slot_code,
   output logic          vid_wr_en,
   output logic          scph_en
);
   import cis_pkg::*;

   localparam logic [CW-1:0] U_IX = CW'(VID_SLOTS);
   localparam logic [CW-1:0] V_IX = CW'(VID_SLOTS + 1);

   slot_kind_e kind;

   always_comb begin
      if (slot_ix == U_IX)
         kind = SLOT_U;
      else if (slot_ix == V_IX)
         kind = SLOT_V;
      else
         kind = SLOT_VID;
   end

   assign slot_code = kind;
   assign vid_wr_en = samp_en && (kind != SLOT_U);
   assign scph_en   = samp_en && first_pass && (kind == SLOT_V);
endmodule

// File: rtl/chroma_interleave_seq.sv
module chroma_interleave_seq #(
   parameter int SLOTS     = 13,
   parameter int VID_SLOTS = 11,
   parameter bit ROTATE    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       samp_en,
   input  logic       h_trig,
   input  logic       v_trig,
   output logic [1:0] slot_code,
   output logic       vid_wr_en,
   output logic       scph_en
);
   localparam int CW = $clog2(SLOTS);

   generate
      if (SLOTS != VID_SLOTS + 2) begin : g_bad_slots
         $error("SLOTS must equal VID_SLOTS plus the two chroma slots");
      end
      if (VID_SLOTS < 1) begin : g_bad_vid
         $error("VID_SLOTS must be at least 1");
      end
   endgenerate

   logic [CW-1:0] line_ofs;
   logic [CW-1:0] slot_ix;
   logic          first_pass;

   cis_line_ofs #(.SLOTS(SLOTS), .ROTATE(ROTATE)) u_ofs (
      .clk    (clk),
      .rst_n  (rst_n),
      .h_trig (h_trig),
      .v_trig (v_trig),
      .ofs    (line_ofs)
   );

   cis_slot_ctr #(.SLOTS(SLOTS)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .samp_en    (samp_en),
      .h_trig     (h_trig),
      .v_trig     (v_trig),
      .ofs_in     (line_ofs),
      .slot_ix    (slot_ix),
      .first_pass (first_pass)
   );

   cis_decode #(.SLOTS(SLOTS), .VID_SLOTS(VID_SLOTS)) u_dec (
      .samp_en    (samp_en),
      .slot_ix    (slot_ix),
      .first_pass (first_pass),
      .slot_code  (slot_code),
      .vid_wr_en  (vid_wr_en),
      .scph_en    (scph_en)
   );
endmodule

// File: rtl/cis_chk.sv
module cis_chk #(
   parameter int  SLOTS = 13,
   localparam int CW    = $clog2(SLOTS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          samp_en,
   input logic          h_trig,
   input logic          v_trig,
   input logic [1:0]    slot_code,
   input logic          vid_wr_en,
   input logic          scph_en,
   input logic [CW-1:0] slot_ix,
   input logic [CW-1:0] line_ofs
);
   localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

   // R1
   offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_ofs <= LAST) && (slot_ix <= LAST));

   // R2
   slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!samp_en && !h_trig && !v_trig) |=> $stable(slot_ix));

   // R2
   slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_en && !h_trig && !v_trig && slot_ix == LAST) |=> (slot_ix == '0));

   // R3
   code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_code != 2'b11);

   // R4
   wr_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vid_wr_en |-> samp_en);

   // R4
   u_not_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_en && slot_code == 2'b01) |-> !vid_wr_en);

   // R5
   line_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (h_trig && !v_trig) |=> (slot_ix == $past(line_ofs)));

   // R6
   field_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      v_trig |=> (slot_ix == '0 && line_ofs == '0));

   // R7
   scph_in_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scph_en |-> (samp_en && slot_code == 2'b10));
endmodule

bind chroma_interleave_seq cis_chk #(.SLOTS(SLOTS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .samp_en   (samp_en),
   .h_trig    (h_trig),
   .v_trig    (v_trig),
   .slot_code (slot_code),
   .vid_wr_en (vid_wr_en),
   .scph_en   (scph_en),
   .slot_ix   (slot_ix),
   .line_ofs  (line_ofs)
);

// File: tb/sim_chroma_interleave_seq.sv
module sim_chroma_interleave_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       samp_en = 1'b0;
   logic       h_trig = 1'b0;
   logic       v_trig = 1'b0;
   logic [1:0] slot_code;
   logic       vid_wr_en;
   logic       scph_en;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   chroma_interleave_seq u0 (
      .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .h_trig(h_trig), .v_trig(v_trig),
      .slot_code(slot_code), .vid_wr_en(vid_wr_en), .scph_en(scph_en)
   );

   // Row: {h_trig, v_trig, samp_en, exp slot_code[1:0], exp vid_wr_en, exp scph_en}
   localparam int NV = 30;
   localparam logic [6:0] VEC [NV] = '{
      7'b000_00_0_0,                                         // R1 idle after reset
      7'b100_00_0_0,                                         // R5 line start, offset 0
      7'b001_00_1_0, 7'b001_00_1_0, 7'b001_00_1_0, 7'b001_00_1_0,
      7'b001_00_1_0, 7'b001_00_1_0, 7'b001_00_1_0, 7'b001_00_1_0,
      7'b001_00_1_0, 7'b001_00_1_0, 7'b001_00_1_0,          // R3 slots 0..10 video
      7'b001_01_0_0,                                         // R4 U slot not written
      7'b001_10_1_1,                                         // R7 first-pass V
      7'b001_00_1_0,                                         // R2 wrap to slot 0
      7'b101_00_1_0,                                         // R5 trigger wins over enable
      7'b001_00_1_0, 7'b001_00_1_0, 7'b001_00_1_0, 7'b001_00_1_0,
      7'b001_00_1_0, 7'b001_00_1_0, 7'b001_00_1_0, 7'b001_00_1_0,
      7'b001_00_1_0, 7'b001_00_1_0,                          // slots 1..10
      7'b001_01_0_0,                                         // R3 U at index 11
      7'b001_10_1_1,                                         // R7 V at index 12
      7'b000_00_0_0                                          // R4 no write without enable
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input logic h, input logic v, input logic en);
      @(negedge clk);
      h_trig  = h;
      v_trig  = v;
      samp_en = en;
      #1;
   endtask

   // Enabled samples taken before the U slot shows
   task automatic steps_to_u(output int cnt);
      cnt = 0;
      for (int i = 0; i < 14; i++) begin
         cyc(1'b0, 1'b0, 1'b1);
         if (slot_code == 2'b01) break;
         cnt++;
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #800000;
      n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      int cnt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // Vector table
      for (int r = 0; r < NV; r++) begin
         cyc(VEC[r][6], VEC[r][5], VEC[r][4]);
         chk($sformatf("R3 vec%0d slot_code", r), int'(slot_code), int'(VEC[r][3:2]));
         chk($sformatf("R4 vec%0d vid_wr_en", r), int'(vid_wr_en), int'(VEC[r][1]));
         chk($sformatf("R7 vec%0d scph_en", r), int'(scph_en), int'(VEC[r][0]));
      end

      // R6: field start with a line trigger in the same cycle; the line trigger is ignored
      cyc(1'b1, 1'b1, 1'b0);
      for (int k = 0; k < 14; k++) begin
         cyc(1'b1, 1'b0, 1'b0);
         steps_to_u(cnt);
         chk($sformatf("R8 line %0d start", k), cnt, (11 - (k % 13) + 13) % 13);
         cyc(1'b0, 1'b0, 1'b1);
         chk($sformatf("R3 line %0d V code", k), int'(slot_code), 2);
         chk($sformatf("R7 line %0d scph", k), int'(scph_en), (k % 13 == 12) ? 0 : 1);
         if (k == 2) begin
            repeat (12) cyc(1'b0, 1'b0, 1'b1);
            cyc(1'b0, 1'b0, 1'b1);
            chk("R7 second-pass V scph", int'(scph_en), 0);
            chk("R2 second-pass V code", int'(slot_code), 2);
         end
      end

      // R2: hold without enable (line trigger 14 loads offset 1)
      cyc(1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 6; i++) begin
         cyc(1'b0, 1'b0, 1'b0);
         chk("R4 idle no write", int'(vid_wr_en), 0);
         chk("R7 idle no scph", int'(scph_en), 0);
      end
      steps_to_u(cnt);
      chk("R2 hold keeps slot 1", cnt, 10);

      // R1: reset in mid-line returns to slot 0 and offset 0
      cyc(1'b0, 1'b0, 1'b0);
      rst_n = 1'b0;
      #2;
      chk("R1 reset slot code", int'(slot_code), 0);
      chk("R1 reset no write", int'(vid_wr_en), 0);
      @(negedge clk);
      rst_n = 1'b1;
      steps_to_u(cnt);
      chk("R1 reset slot 0", cnt, 11);
      cyc(1'b0, 1'b0, 1'b0);
      cyc(1'b1, 1'b0, 1'b0);
      steps_to_u(cnt);
      chk("R1 reset offset 0", cnt, 11);

      cyc(1'b0, 1'b0, 1'b0);
      finish_run();
   end
endmodule